// File: doc/BRIEF.md
# SDRAM Bank Command Tracker

This block follows the command stream that a memory controller drives onto a four-bank synchronous DRAM, and keeps the controller's picture of each bank. On every rising clock edge it samples the chip-select, the three strobe lines (row strobe, column strobe, write enable), the two-bit bank select, the auto-close line and the row address. From these it decodes open-row, column-read, column-write and close-bank commands. It updates, for every bank, whether a row is open and which row it is.

Reads and writes can close their bank automatically when the auto-close line is high. A close-bank command can close a single bank or all four at once. A read-data-valid strobe is produced through a shift register that is as long as the CAS latency, so reads issued back to back each get their own strobe. Commands that break the open-before-access rule raise a one-cycle error pulse and leave the bank state alone. The block is used as a shadow model beside a controller, or as a protocol monitor in front of a memory port.

Top module: `sdram_bank_tracker`

## Requirements
- R1: When `cs_n` is high at a rising edge, no command is decoded: `bank_active`, `open_row` and `cmd_err` are unchanged or low after that edge, and no `rd_valid` pulse results.
- R2: With `cs_n` low, `{ras_n,cas_n,we_n}` decodes as 011 open-row, 101 read, 100 write, 010 close-bank and 111 no-operation. Every other code acts as no-operation. An open-row command to an idle bank sets bit `ba` of `bank_active` after that edge.
- R3: A legal read or write with `a10` low leaves the addressed bank open with its row unchanged.
- R4: A legal read or write with `a10` high clears bit `ba` of `bank_active` after the same edge, because the burst length is one.
- R5: A close-bank command with `a10` high clears all four bits of `bank_active`, whatever `ba` holds.
- R6: A close-bank command with `a10` low clears only bit `ba`, and the other banks keep their state and rows.
- R7: A legal read sampled at edge N drives `rd_valid` high for exactly the one cycle that ends at edge N+`CAS_LAT`, which is after edge N+`CAS_LAT`-1. Reads on consecutive edges give strobes on consecutive cycles. Writes give no strobe.
- R8: A read or write to an idle bank, or an open-row command to a bank that is already open, raises `cmd_err` for the one cycle after that edge. It changes no bank state and gives no `rd_valid`.
- R9: While `rst_n` is low, every bank is idle, `cmd_err` is low and pending read strobes are cleared, so none of them appears after reset is released.
- R10: An open-row command stores `row_addr` in slice `ba` of `open_row` (bits `ba*ROW_W` upward), and the slice holds that value while the bank stays open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| a10 | input | 1 | Auto-close on read/write, close-all on close-bank |
| row_addr | input | ROW_W (13) | Row address sampled with open-row |
| bank_active | output | 4 | Bit i high when bank i has an open row |
| open_row | output | 4*ROW_W | Stored row of bank i at bits i*ROW_W upward |
| cmd_err | output | 1 | One-cycle pulse after an illegal command |
| rd_valid | output | 1 | One-cycle read-data-valid strobe |

## Verification
On every cycle, the bound assertions check the following: deselected edges do not change state, close-all and auto-close clear the right bits, the error pulse comes only after an illegal command with the state held, and an open-row command stores the sampled row. The latency of `rd_valid`, back-to-back strobes, the absence of strobes after writes, erroneous reads or deselected reads, and the clearing of in-flight strobes by reset are shown only by the bench's directed scenarios. The same applies to the illegal strobe codes that act as no-operation.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } sbt_cmd_e;

  // strobe codes {ras_n, cas_n, we_n}
  localparam logic [2:0] CODE_ACT = 3'b011;
  localparam logic [2:0] CODE_RD  = 3'b101;
  localparam logic [2:0] CODE_WR  = 3'b100;
  localparam logic [2:0] CODE_PRE = 3'b010;

endpackage

// File: rtl/sbt_cmd_decode.sv
module sbt_cmd_decode
  import sbt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BA_W-1:0]      ba,
  output sbt_cmd_e             cmd,
  output logic [NUM_BANKS-1:0] bank_sel
);

  always_comb begin
    cmd = CMD_NOP;
    if (!cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        CODE_ACT: cmd = CMD_ACT;
        CODE_RD:  cmd = CMD_RD;
        CODE_WR:  cmd = CMD_WR;
        CODE_PRE: cmd = CMD_PRE;
        default:  cmd = CMD_NOP;
      endcase
    end
  end

  always_comb begin
    bank_sel = '0;
    bank_sel[ba] = 1'b1;
  end

endmodule

// File: rtl/sbt_bank.sv
module sbt_bank #(
  parameter int ROW_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_en,
  input  logic             close_en,
  input  logic [ROW_W-1:0] row_in,
  output logic             active,
  output logic [ROW_W-1:0] row
);

  logic             active_q, active_d;
  logic [ROW_W-1:0] row_q;

  // next state: a bank is never opened and closed on one edge
  always_comb begin
    active_d = active_q;
    if (close_en)
      active_d = 1'b0;
    else if (open_en)
      active_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      active_q <= 1'b0;
    else
      active_q <= active_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      row_q <= '0;
    else if (open_en)
      row_q <= row_in;
  end

  assign active = active_q;
  assign row    = row_q;

endmodule

// File: rtl/sbt_rd_pipe.sv
module sbt_rd_pipe #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_fire,
  output logic rd_valid
);

  logic [DEPTH-1:0] sr_q, sr_d;

  generate
    if (DEPTH == 1) begin : g_single
      always_comb sr_d = rd_fire;
    end else begin : g_chain
      always_comb sr_d = {sr_q[DEPTH-2:0], rd_fire};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sr_q <= '0;
    else
      sr_q <= sr_d;
  end

  assign rd_valid = sr_q[DEPTH-1];

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sbt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int CAS_LAT   = 3,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs_n,
  input  logic                       ras_n,
  input  logic                       cas_n,
  input  logic                       we_n,
  input  logic [BA_W-1:0]            ba,
  input  logic                       a10,
  input  logic [ROW_W-1:0]           row_addr,
  output logic [NUM_BANKS-1:0]       bank_active,
  output logic [NUM_BANKS*ROW_W-1:0] open_row,
  output logic                       cmd_err,
  output logic                       rd_valid
);

  sbt_cmd_e             cmd;
  logic [NUM_BANKS-1:0] bank_sel;
  logic [NUM_BANKS-1:0] open_en, close_en;
  logic                 tgt_active;
  logic                 is_col;
  logic                 err_d, err_q;
  logic                 rd_fire;

  sbt_cmd_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .ba       (ba),
    .cmd      (cmd),
    .bank_sel (bank_sel)
  );

  assign tgt_active = bank_active[ba];
  assign is_col     = (cmd == CMD_RD) || (cmd == CMD_WR);

  generate
    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
      always_comb begin
        open_en[i]  = (cmd == CMD_ACT) && bank_sel[i] && !bank_active[i];
        close_en[i] = ((cmd == CMD_PRE) && (a10 || bank_sel[i])) ||
                      (is_col && a10 && bank_sel[i] && bank_active[i]);
      end

      sbt_bank #(.ROW_W(ROW_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .open_en  (open_en[i]),
        .close_en (close_en[i]),
        .row_in   (row_addr),
        .active   (bank_active[i]),
        .row      (open_row[i*ROW_W +: ROW_W])
      );
    end
  endgenerate

  always_comb begin
    err_d = ((cmd == CMD_ACT) && tgt_active) || (is_col && !tgt_active);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      err_q <= 1'b0;
    else
      err_q <= err_d;
  end

  assign cmd_err = err_q;
  assign rd_fire = (cmd == CMD_RD) && tgt_active;

  sbt_rd_pipe #(.DEPTH(CAS_LAT)) u_rd_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_fire  (rd_fire),
    .rd_valid (rd_valid)
  );

endmodule

// File: rtl/sbt_checker.sv
module sbt_checker #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cs_n,
  input logic                       ras_n,
  input logic                       cas_n,
  input logic                       we_n,
  input logic [BA_W-1:0]            ba,
  input logic                       a10,
  input logic [ROW_W-1:0]           row_addr,
  input logic [NUM_BANKS-1:0]       bank_active,
  input logic [NUM_BANKS*ROW_W-1:0] open_row,
  input logic                       cmd_err
);

  logic [2:0]       code;
  logic             c_act, c_col, c_pre;
  logic             bad_cmd;
  logic [BA_W-1:0]  ba_q;
  logic [ROW_W-1:0] row_q;
  logic [ROW_W-1:0] row_of_ba_q;

  assign code    = {ras_n, cas_n, we_n};
  assign c_act   = !cs_n && (code == 3'b011);
  assign c_col   = !cs_n && ((code == 3'b101) || (code == 3'b100));
  assign c_pre   = !cs_n && (code == 3'b010);
  assign bad_cmd = (c_act && bank_active[ba]) || (c_col && !bank_active[ba]);

  always_ff @(posedge clk) begin
    ba_q  <= ba;
    row_q <= row_addr;
  end

  assign row_of_ba_q = open_row[ba_q*ROW_W +: ROW_W];

  AST_DESELECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ($stable(bank_active) && $stable(open_row) && !cmd_err)); // R1

  AST_OPEN_SETS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (c_act && !bank_active[ba]) |=> bank_active[ba_q]); // R2

  AST_AUTO_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (c_col && a10 && bank_active[ba]) |=> !bank_active[ba_q]); // R4

  AST_CLOSE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (c_pre && a10) |=> (bank_active == '0)); // R5

  AST_ERR_ONLY_ON_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_cmd |=> !cmd_err); // R8

  AST_ERR_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cmd |=> (cmd_err && $stable(bank_active) && $stable(open_row))); // R8

  AST_ROW_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    (c_act && !bank_active[ba]) |=> (row_of_ba_q == row_q)); // R10

endmodule

bind sdram_bank_tracker sbt_checker #(
  .NUM_BANKS (NUM_BANKS),
  .ROW_W     (ROW_W)
) u_sbt_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_n        (cs_n),
  .ras_n       (ras_n),
  .cas_n       (cas_n),
  .we_n        (we_n),
  .ba          (ba),
  .a10         (a10),
  .row_addr    (row_addr),
  .bank_active (bank_active),
  .open_row    (open_row),
  .cmd_err     (cmd_err)
);

// File: tb/test_sdram_bank_tracker.sv
`timescale 1ns/1ps
module test_sdram_bank_tracker;

  localparam int NB = 4;
  localparam int RW = 13;
  localparam int CL = 3;
  localparam logic [2:0] K_ACT = 3'b011, K_RD = 3'b101, K_WR = 3'b100,
                         K_PRE = 3'b010, K_NOP = 3'b111;

  logic clk, rst_n, cs_n, ras_n, cas_n, we_n, a10;
  logic [1:0] ba;
  logic [RW-1:0] row_addr;
  logic [NB-1:0] bank_active;
  logic [NB*RW-1:0] open_row;
  logic cmd_err, rd_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  sdram_bank_tracker #(.NUM_BANKS(NB), .ROW_W(RW), .CAS_LAT(CL)) i_sdram_bank_tracker (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .a10(a10), .row_addr(row_addr),
    .bank_active(bank_active), .open_row(open_row),
    .cmd_err(cmd_err), .rd_valid(rd_valid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [RW-1:0] row_of(input int b);
    return open_row[b*RW +: RW];
  endfunction

  // called at a falling edge; returns at the falling edge after the sampling edge
  task automatic issue(input logic sel_n, input logic [2:0] code, input logic [1:0] b,
                       input logic ap, input logic [RW-1:0] r);
    cs_n = sel_n; {ras_n, cas_n, we_n} = code; ba = b; a10 = ap; row_addr = r;
    @(posedge clk);
    @(negedge clk);
    cs_n = 1'b0; {ras_n, cas_n, we_n} = K_NOP; a10 = 1'b0;
  endtask

  task automatic idle_cycle();
    @(negedge clk);
  endtask

  // after issue returns (k=0), check rd_valid at k=1..CL
  task automatic watch_rdv(input string req, input bit expect_pulse);
    for (int k = 1; k <= CL; k++) begin
      idle_cycle();
      chk(req, rd_valid, (expect_pulse && k == CL-1) ? 1 : 0);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cs_n = 1'b1; {ras_n, cas_n, we_n} = K_NOP; ba = 0; a10 = 0; row_addr = 0;
    repeat (3) @(negedge clk);
    chk("R9 banks idle in reset", bank_active, 0);
    chk("R9 err low in reset", cmd_err, 0);
    chk("R9 rd_valid low in reset", rd_valid, 0);
    rst_n = 1'b1;
    idle_cycle();
  endtask

  task automatic t_open_access();
    issue(0, K_ACT, 2'd1, 0, 13'h0123);
    chk("R2 open bank1", bank_active, 4'b0010);
    chk("R10 row stored bank1", row_of(1), 13'h0123);
    chk("R2 no err on legal open", cmd_err, 0);
    issue(0, K_RD, 2'd1, 0, 13'h1FFF);
    chk("R3 read a10=0 keeps bank", bank_active, 4'b0010);
    chk("R3 row unchanged", row_of(1), 13'h0123);
    watch_rdv("R7 read strobe latency", 1);
    issue(0, K_WR, 2'd1, 0, 0);
    chk("R3 write a10=0 keeps bank", bank_active, 4'b0010);
    chk("R2 no err on legal write", cmd_err, 0);
    watch_rdv("R7 no strobe for write", 0);
  endtask

  task automatic t_deselect();
    issue(1, K_ACT, 2'd0, 0, 13'h0AAA);
    chk("R1 deselected open ignored", bank_active, 4'b0010);
    issue(1, K_PRE, 2'd1, 1, 0);
    chk("R1 deselected close-all ignored", bank_active, 4'b0010);
    issue(1, K_RD, 2'd0, 0, 0);
    chk("R1 deselected read to idle no err", cmd_err, 0);
    issue(1, K_RD, 2'd1, 1, 0);
    chk("R1 deselected auto-close ignored", bank_active, 4'b0010);
    watch_rdv("R1 deselected read no strobe", 0);
  endtask

  task automatic t_other_codes();
    logic [2:0] codes [3] = '{3'b000, 3'b001, 3'b110};
    for (int i = 0; i < 3; i++) begin
      issue(0, codes[i], 2'd1, 1, 13'h0055);
      chk("R2 unused code is no-op bank", bank_active, 4'b0010);
      chk("R2 unused code no err", cmd_err, 0);
      chk("R2 unused code keeps row", row_of(1), 13'h0123);
    end
    watch_rdv("R2 unused code no strobe", 0);
  endtask

  task automatic t_auto_close();
    issue(0, K_RD, 2'd1, 1, 0);
    chk("R4 read a10=1 closes bank1", bank_active, 4'b0000);
    watch_rdv("R7 auto-close read still strobes", 1);
    issue(0, K_ACT, 2'd3, 0, 13'h1ABC);
    chk("R2 open bank3", bank_active, 4'b1000);
    issue(0, K_WR, 2'd3, 1, 0);
    chk("R4 write a10=1 closes bank3", bank_active, 4'b0000);
  endtask

  task automatic t_close();
    issue(0, K_ACT, 2'd0, 0, 13'h0010);
    issue(0, K_ACT, 2'd1, 0, 13'h0011);
    issue(0, K_ACT, 2'd2, 0, 13'h0012);
    chk("R2 three banks open", bank_active, 4'b0111);
    issue(0, K_PRE, 2'd1, 0, 0);
    chk("R6 single close bank1 only", bank_active, 4'b0101);
    chk("R6 bank0 row kept", row_of(0), 13'h0010);
    chk("R6 bank2 row kept", row_of(2), 13'h0012);
    issue(0, K_PRE, 2'd3, 0, 0);
    chk("R6 close idle bank3 harmless", {cmd_err, bank_active}, 5'b00101);
    issue(0, K_PRE, 2'd1, 1, 0);
    chk("R5 close-all ignores ba", bank_active, 4'b0000);
  endtask

  task automatic t_errors();
    issue(0, K_RD, 2'd0, 0, 0);
    chk("R8 read idle bank err", cmd_err, 1);
    chk("R8 read idle keeps state", bank_active, 4'b0000);
    idle_cycle();
    chk("R8 err is one cycle", cmd_err, 0);
    issue(0, K_RD, 2'd0, 1, 0);
    watch_rdv("R8 no strobe for bad read", 0);
    issue(0, K_WR, 2'd2, 0, 0);
    chk("R8 write idle bank err", cmd_err, 1);
    issue(0, K_ACT, 2'd2, 0, 13'h0777);
    chk("R8 legal open clears err", cmd_err, 0);
    issue(0, K_ACT, 2'd2, 0, 13'h0999);
    chk("R8 open on open bank err", cmd_err, 1);
    chk("R10 row not overwritten", row_of(2), 13'h0777);
    chk("R8 bank still open", bank_active, 4'b0100);
    issue(0, K_PRE, 2'd2, 0, 0);
    issue(0, K_ACT, 2'd2, 0, 13'h0999);
    chk("R10 new row after close", row_of(2), 13'h0999);
  endtask

  task automatic t_back_to_back();
    issue(0, K_RD, 2'd2, 0, 0);
    issue(0, K_RD, 2'd2, 0, 0);
    chk("R7 b2b k1", rd_valid, 0);
    idle_cycle();
    chk("R7 b2b first strobe", rd_valid, 1);
    idle_cycle();
    chk("R7 b2b second strobe", rd_valid, 1);
    idle_cycle();
    chk("R7 b2b strobe ends", rd_valid, 0);
  endtask

  task automatic t_reset_mid();
    issue(0, K_RD, 2'd2, 0, 0);
    rst_n = 1'b0;
    idle_cycle();
    chk("R9 reset closes banks", bank_active, 0);
    rst_n = 1'b1;
    for (int k = 0; k < CL + 1; k++) begin
      chk("R9 pending strobe cleared", rd_valid, 0);
      idle_cycle();
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_open_access();
    t_deselect();
    t_other_codes();
    t_auto_close();
    t_close();
    t_errors();
    t_back_to_back();
    t_reset_mid();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule